// File: doc/BRIEF.md
# Strobed Window Discriminator

This block decides whether a digital amplitude word falls inside an acceptance window. The window is set by a lower level and an upper setting. A mode bit chooses how the upper setting is read. In normal mode it is an absolute ceiling. In window mode it is a width stacked on top of the lower level, and that sum is clamped at full scale.

The decision is not continuous. A stop strobe arms a fixed delay. When the delay ends, the comparison is taken once and latched into `in_window`, and `verdict_vld` pulses for one cycle. The latched flag stays high until the cycle clear (`clr`) ends the measurement. While a decision is pending or held, further stop strobes are ignored. A clear that arrives before the delay has elapsed throws the pending comparison away.

Top module: `strobed_window_disc`

## Requirements
- R1: After `rst_n` is released, `in_window` and `verdict_vld` are both 0.
- R2: With `win_mode`=0, the verdict is 1 exactly when `amp` > `lo_lvl` and `amp` <= `up_set` (unsigned); an amplitude equal to or below the lower level is rejected.
- R3: With `win_mode`=0 and `up_set` <= `lo_lvl`, the verdict is always 0.
- R4: With `win_mode`=1, the verdict is 1 exactly when `lo_lvl` < `amp` <= `lo_lvl`+`up_set`.
- R5: In window mode, the sum `lo_lvl`+`up_set` saturates at 2^AW-1 instead of wrapping, so a full-scale amplitude above the lower level is accepted whenever the sum overflows.
- R6: When `stop_in` is sampled high at a clock edge while idle, `verdict_vld` is high for exactly one cycle, DLY_CYC clock edges later. At that same edge `in_window` takes the verdict from the inputs present just before it.
- R7: Once latched, `in_window` keeps its value until `clr` is asserted. Stop strobes that arrive after the decision produce no new verdict.
- R8: `clr` clears `in_window`. A `clr` that arrives before the delay ends cancels the pending comparison, and no `verdict_vld` follows.
- R9: A second `stop_in` that arrives while the delay is running neither restarts nor shifts the delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous cycle clear |
| stop_in | input | 1 | Stop strobe that arms the sampling delay |
| win_mode | input | 1 | 0: upper setting is absolute; 1: upper setting is a width above the lower level |
| amp | input | AW | Measured amplitude |
| lo_lvl | input | AW | Lower level |
| up_set | input | AW | Upper setting (limit or width) |
| in_window | output | 1 | Latched verdict, held until clear |
| verdict_vld | output | 1 | One-cycle pulse when the verdict is taken |

## Verification
Random words in both modes are spread across the full range. This separates the strict lower bound from the inclusive upper bound, and separates an absolute ceiling from a relative one. Directed cases sit exactly on `lo_lvl`, on the upper limit and one above it. They also include an inverted limit in normal mode and window sums that overflow. These expose off-by-one errors and a wrapping adder. Timing patterns cover a clear that lands mid-delay, a repeated stop during the delay and a stop after the decision. They distinguish a delay that restarts or a verdict that is re-taken from the intended single sample.

// File: rtl/wdisc_pkg.sv
package wdisc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_HELD = 2'd2
  } wd_state_e;
endpackage

// File: rtl/wdisc_limit.sv
module wdisc_limit #(
  parameter int AW = 10
) (
  input  logic [AW-1:0] lo_lvl,
  input  logic [AW-1:0] up_set,
  input  logic          win_mode,
  output logic [AW-1:0] hi_lim
);
  // Adds with one extra bit and clamps to full scale on carry out.
  function automatic logic [AW-1:0] sat_add(input logic [AW-1:0] a,
                                            input logic [AW-1:0] b);
    logic [AW:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[AW] ? {AW{1'b1}} : s[AW-1:0];
  endfunction

  always_comb hi_lim = win_mode ? sat_add(lo_lvl, up_set) : up_set;
endmodule

// File: rtl/wdisc_cmp.sv
module wdisc_cmp #(
  parameter int AW = 10
) (
  input  logic [AW-1:0] amp,
  input  logic [AW-1:0] lo_lvl,
  input  logic [AW-1:0] hi_lim,
  output logic          pass
);
  function automatic logic inside_win(input logic [AW-1:0] a,
                                      input logic [AW-1:0] lo,
                                      input logic [AW-1:0] hi);
    return (a > lo) && (a <= hi);
  endfunction

  always_comb pass = inside_win(amp, lo_lvl, hi_lim);
endmodule

// File: rtl/wdisc_seq.sv
module wdisc_seq #(
  parameter int DLY_CYC = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic stop_in,
  input  logic pass,
  output logic stop_acc,
  output logic sample_now,
  output logic in_window,
  output logic verdict_vld
);
  import wdisc_pkg::*;

  localparam int CW = (DLY_CYC < 2) ? 1 : $clog2(DLY_CYC);
  localparam logic [CW-1:0] LAST = CW'(DLY_CYC - 1);

  wd_state_e     state;
  logic [CW-1:0] cnt;

  assign stop_acc   = (state == ST_IDLE) && stop_in && !clr;
  assign sample_now = (state == ST_WAIT) && (cnt == LAST) && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      in_window   <= 1'b0;
      verdict_vld <= 1'b0;
    end else if (clr) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      in_window   <= 1'b0;
      verdict_vld <= 1'b0;
    end else begin
      verdict_vld <= 1'b0;
      case (state)
        ST_IDLE: if (stop_acc) begin
          state <= ST_WAIT;
          cnt   <= '0;
        end
        ST_WAIT: if (sample_now) begin
          state       <= ST_HELD;
          in_window   <= pass;
          verdict_vld <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: state <= ST_HELD;
      endcase
    end
  end
endmodule

// File: rtl/strobed_window_disc.sv
module strobed_window_disc #(
  parameter int AW      = 10,
  parameter int DLY_CYC = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          stop_in,
  input  logic          win_mode,
  input  logic [AW-1:0] amp,
  input  logic [AW-1:0] lo_lvl,
  input  logic [AW-1:0] up_set,
  output logic          in_window,
  output logic          verdict_vld
);
  logic [AW-1:0] hi_lim;
  logic          pass;
  logic          stop_acc;
  logic          sample_now;

  wdisc_limit #(.AW(AW)) u_limit (
    .lo_lvl(lo_lvl), .up_set(up_set), .win_mode(win_mode), .hi_lim(hi_lim)
  );

  wdisc_cmp #(.AW(AW)) u_cmp (
    .amp(amp), .lo_lvl(lo_lvl), .hi_lim(hi_lim), .pass(pass)
  );

  wdisc_seq #(.DLY_CYC(DLY_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .clr(clr), .stop_in(stop_in), .pass(pass),
    .stop_acc(stop_acc), .sample_now(sample_now),
    .in_window(in_window), .verdict_vld(verdict_vld)
  );
endmodule

// File: rtl/wdisc_chk.sv
module wdisc_chk #(
  parameter int AW      = 10,
  parameter int DLY_CYC = 30
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr,
  input logic          win_mode,
  input logic [AW-1:0] amp,
  input logic [AW-1:0] lo_lvl,
  input logic [AW-1:0] up_set,
  input logic          stop_acc,
  input logic          in_window,
  input logic          verdict_vld
);
  localparam int AGW = $clog2(DLY_CYC + 3);
  localparam logic [AGW-1:0] AGE_MAX = AGW'(DLY_CYC + 2);
  localparam logic [AGW-1:0] AGE_HIT = AGW'(DLY_CYC + 1);

  // Edges seen since the last accepted stop, saturating.
  logic [AGW-1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                age <= AGE_MAX;
    else if (stop_acc)         age <= AGW'(1);
    else if (age != AGE_MAX)   age <= age + 1'b1;
  end

  AST_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_vld |=> !verdict_vld); // R6
  AST_VLD_AFTER_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_vld |-> (age == AGE_HIT)); // R6
  AST_HOLD_TILL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_window && !clr) |=> in_window); // R7
  AST_RISE_WITH_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_window) |-> verdict_vld); // R7
  AST_CLR_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!in_window && !verdict_vld)); // R8
  AST_BAD_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_vld && $past(!win_mode && (up_set <= lo_lvl))) |-> !in_window); // R3
  AST_AT_OR_BELOW_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_vld && $past(amp <= lo_lvl)) |-> !in_window); // R2
endmodule

bind strobed_window_disc wdisc_chk #(.AW(AW), .DLY_CYC(DLY_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .win_mode(win_mode), .amp(amp),
  .lo_lvl(lo_lvl), .up_set(up_set), .stop_acc(stop_acc),
  .in_window(in_window), .verdict_vld(verdict_vld)
);

// File: tb/sim_strobed_window_disc.sv
module sim_strobed_window_disc;
  localparam int AW  = 10;
  localparam int DLY = 30;
  localparam int FS  = (1 << AW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, stop_in = 1'b0, win_mode = 1'b0;
  logic [AW-1:0] amp = '0, lo_lvl = '0, up_set = '0;
  logic in_window, verdict_vld;

  int n_chk = 0, n_bad = 0, vld_cnt = 0;

  always #10 clk = ~clk;

  strobed_window_disc #(.AW(AW), .DLY_CYC(DLY)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .stop_in(stop_in), .win_mode(win_mode),
    .amp(amp), .lo_lvl(lo_lvl), .up_set(up_set),
    .in_window(in_window), .verdict_vld(verdict_vld)
  );

  always @(negedge clk) if (verdict_vld) vld_cnt++;

  function automatic bit model(int a, int l, int u, bit m);
    int top;
    top = m ? ((l + u > FS) ? FS : l + u) : u;
    return (a > l) && (a <= top);
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_clr();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  // One full measurement: stop, wait, check verdict timing and value, clear.
  task automatic measure(string req, int a, int l, int u, bit m);
    bit e;
    e = model(a, l, u, m);
    @(negedge clk);
    amp = AW'(a); lo_lvl = AW'(l); up_set = AW'(u); win_mode = m;
    stop_in = 1'b1;
    @(negedge clk) stop_in = 1'b0;
    repeat (DLY - 1) @(negedge clk);
    check({req, " R6 early"}, verdict_vld, 0);
    @(negedge clk);
    check({req, " R6 vld"}, verdict_vld, 1);
    check(req, in_window, e);
    repeat (3) @(negedge clk);
    check({req, " R7 held"}, in_window, e);
    pulse_clr();
    check({req, " R8 cleared"}, in_window, 0);
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    check("R1 window", in_window, 0);
    check("R1 vld", verdict_vld, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", in_window, 0);

    measure("R2 inside", 300, 100, 500, 0);
    measure("R2 at upper", 500, 100, 500, 0);
    measure("R2 above upper", 501, 100, 500, 0);
    measure("R2 at lower", 100, 100, 500, 0);
    measure("R3 inverted", 300, 400, 200, 0);
    measure("R3 equal", 400, 400, 400, 0);
    measure("R4 inside", 550, 400, 200, 1);
    measure("R4 at sum", 600, 400, 200, 1);
    measure("R4 above sum", 601, 400, 200, 1);
    measure("R4 at lower", 400, 400, 200, 1);
    measure("R5 saturate", FS, 900, 500, 1);
    measure("R5 overflow low", 50, 900, 500, 1);

    void'($urandom(32'd4242));
    for (int i = 0; i < 60; i++) begin
      measure((i % 2) ? "R4 random" : "R2 random",
              int'($urandom_range(FS)), int'($urandom_range(FS)),
              int'($urandom_range(FS)), bit'(i % 2));
    end

    // R7: stops after the decision give no new verdict
    base = vld_cnt;
    @(negedge clk);
    amp = 10'd300; lo_lvl = 10'd100; up_set = 10'd500; win_mode = 1'b0;
    stop_in = 1'b1;
    @(negedge clk) stop_in = 1'b0;
    repeat (DLY + 2) @(negedge clk);
    stop_in = 1'b1;
    @(negedge clk) stop_in = 1'b0;
    amp = 10'd0;
    repeat (DLY + 5) @(negedge clk);
    check("R7 one verdict", vld_cnt - base, 1);
    check("R7 still held", in_window, 1);
    pulse_clr();

    // R8: clear mid-delay cancels the comparison
    base = vld_cnt;
    amp = 10'd300;
    stop_in = 1'b1;
    @(negedge clk) stop_in = 1'b0;
    repeat (10) @(negedge clk);
    pulse_clr();
    repeat (DLY + 5) @(negedge clk);
    check("R8 no verdict", vld_cnt - base, 0);
    check("R8 window low", in_window, 0);

    // R9: a second stop during the delay does not move it
    stop_in = 1'b1;
    @(negedge clk) stop_in = 1'b0;
    repeat (5) @(negedge clk);
    stop_in = 1'b1;
    @(negedge clk) stop_in = 1'b0;
    repeat (DLY - 7) @(negedge clk);
    check("R9 early", verdict_vld, 0);
    @(negedge clk);
    check("R9 on time", verdict_vld, 1);
    check("R9 value", in_window, 1);
    pulse_clr();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule